// File: doc/BRIEF.md
# Pretrigger/Posttrigger Acquisition Sequencer

This block steps a waveform capture through its phases, from arming to a finished record. A start strobe launches a capture. The sequencer then counts sample-group clocks, where each clock stands for 32 analog samples written into the sample store as two halves of 16, until the programmed pretrigger amount has been taken. It then raises a holdoff-done flag that arms the external trigger path, and it waits for a synchronized trigger. Sampling continues while it waits. If no trigger ever comes, the store simply keeps filling and the sequencer waits on.

After the trigger, the sequencer counts the programmed number of posttrigger groups. It then raises slow-out, which halts fast sampling and starts conversion readout. The trigger can fall anywhere among the 32 samples of a group. To keep the trigger at an exact position in the record, the sequencer loads a 5-bit in-group trigger offset and lets that many converted samples pass with storage disabled. It then enables storage for a full record of 2048 samples: 1024 for each of two channels, or 512 max/min pairs per channel in envelope mode. After that it blocks further writes and reports done until software clears it.

All inputs are single-cycle enables, synchronous to one clock, with a synchronous active-high reset. Each output is a registered decode of the phase, so it changes in the cycle after the strobe that causes the change.

Top module: `acq_sequencer`

## Requirements
- R1: During reset and after it, holdoff_done, slow_out, store_en and acq_done are all low. Nothing changes until start_stb is seen.
- R2: start_stb starts a capture only from idle and latches pre_count and post_count. A start_stb seen at any other time has no effect, and the counts are not reloaded.
- R3: holdoff_done rises in the cycle after the pre_count-th group_clk that follows the start. If pre_count is 0, it rises in the cycle after start_stb. It stays high until the clear.
- R4: trig_sync has no effect before holdoff_done is high.
- R5: After the trigger, slow_out rises in the cycle after the post_count-th group_clk. If post_count is 0, it rises in the cycle after trig_sync. It stays high until the clear.
- R6: While the sequencer waits for the trigger, group_clk pulses advance nothing. The wait has no time limit.
- R7: trig_loc (0 to 31) is sampled in the cycle in which slow_out is about to rise. store_en then stays low for the first trig_loc sample_stb pulses of readout, which are discarded. If trig_loc is 0, store_en rises together with slow_out.
- R8: store_en is high for exactly 2048 sample_stb pulses. A pulse counts as stored when sample_stb and store_en are both high in the same cycle. In the cycle after the last stored pulse, store_en goes low and acq_done goes high.
- R9: acq_done stays high until clear_stb. clear_stb then returns every output low, to idle. clear_stb has no effect before acq_done is high.
- R10: sample_stb pulses seen before slow_out rises are neither discarded nor stored, and they do not shorten the discard window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_stb | input | 1 | Start-capture strobe from the control-register write |
| clear_stb | input | 1 | Strobe that clears the done state back to idle |
| pre_count | input | 16 | Pretrigger amount in sample groups |
| post_count | input | 16 | Posttrigger amount in sample groups |
| group_clk | input | 1 | One pulse for each 32-sample group entering the store |
| trig_sync | input | 1 | Synchronized record-trigger pulse |
| trig_loc | input | 5 | Position of the trigger inside its 32-sample group |
| sample_stb | input | 1 | One pulse for each converted sample during readout |
| holdoff_done | output | 1 | Pretrigger holdoff met; trigger path armed |
| slow_out | output | 1 | Fast sampling stopped; readout running |
| store_en | output | 1 | The current sample_stb writes to memory |
| acq_done | output | 1 | Record complete |

## Verification
On every cycle, the embedded assertions check several things. Holdoff-done and slow-out rise only after a start, group or trigger pulse. A trigger before holdoff never reaches slow-out. The discard counter stays inside its 5-bit window. Storage ends only into the done state, and done holds until it is cleared. Only the bench's scenarios can show the exact counts: that holdoff and slow-out rise after precisely the programmed number of groups, that exactly trig_loc samples are dropped, that exactly 2048 are stored, and that stray strobes (a restart while busy, an early trigger, early samples, a premature clear) change nothing.

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int CNT_W      = 16,
  parameter int LOC_W      = 5,
  parameter int RECORD_LEN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_stb,
  input  logic             clear_stb,
  input  logic [CNT_W-1:0] pre_count,
  input  logic [CNT_W-1:0] post_count,
  input  logic             group_clk,
  input  logic             trig_sync,
  input  logic [LOC_W-1:0] trig_loc,
  input  logic             sample_stb,
  output logic             holdoff_done,
  output logic             slow_out,
  output logic             store_en,
  output logic             acq_done
);

  localparam logic [CNT_W-1:0] REC = CNT_W'(RECORD_LEN);
  localparam logic [CNT_W-1:0] LOC_MAX = CNT_W'((1 << LOC_W) - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ARM, S_POST, S_DISC, S_STORE, S_DONE
  } phase_t;

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] post_q;

  // entry point of readout: skip the discard window when the offset is zero
  phase_t           rd_state;
  logic [CNT_W-1:0] rd_cnt;
  assign rd_state = (trig_loc == '0) ? S_STORE : S_DISC;
  assign rd_cnt   = (trig_loc == '0) ? REC : CNT_W'(trig_loc);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      post_q <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start_stb) begin
            post_q <= post_count;
            cnt    <= pre_count;
            state  <= (pre_count == '0) ? S_ARM : S_PRE;
          end
        S_PRE:
          if (group_clk) begin
            if (cnt == CNT_W'(1)) state <= S_ARM;
            cnt <= cnt - 1'b1;
          end
        S_ARM:
          if (trig_sync) begin
            if (post_q == '0) begin
              state <= rd_state;
              cnt   <= rd_cnt;
            end else begin
              state <= S_POST;
              cnt   <= post_q;
            end
          end
        S_POST:
          if (group_clk) begin
            if (cnt == CNT_W'(1)) begin
              state <= rd_state;
              cnt   <= rd_cnt;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        S_DISC:
          if (sample_stb) begin
            if (cnt == CNT_W'(1)) begin
              state <= S_STORE;
              cnt   <= REC;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        S_STORE:
          if (sample_stb) begin
            if (cnt == CNT_W'(1)) state <= S_DONE;
            cnt <= cnt - 1'b1;
          end
        S_DONE:
          if (clear_stb) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign holdoff_done = (state != S_IDLE) && (state != S_PRE);
  assign slow_out     = (state == S_DISC) || (state == S_STORE) || (state == S_DONE);
  assign store_en     = (state == S_STORE);
  assign acq_done     = (state == S_DONE);

  AST_HOLDOFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(holdoff_done) |-> ($past(start_stb) || $past(group_clk))); // R3

  AST_EARLY_TRIG: assert property (@(posedge clk) disable iff (rst)
    (state == S_PRE && trig_sync) |=> !slow_out); // R4

  AST_SLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_out) |-> ($past(trig_sync) || $past(group_clk))); // R5

  AST_DISC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state == S_DISC) |-> (cnt != '0 && cnt <= LOC_MAX)); // R7

  AST_STORE_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(store_en) |-> acq_done); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (acq_done && !clear_stb) |=> acq_done); // R9

endmodule

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int REC = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_stb = 0, clear_stb = 0, group_clk = 0, trig_sync = 0, sample_stb = 0;
  logic [15:0] pre_count = 0, post_count = 0;
  logic [4:0]  trig_loc = 0;
  logic holdoff_done, slow_out, store_en, acq_done;

  integer checks = 0, errors = 0, cycles = 0;
  integer ph = 0, left = 0, post_l = 0;
  integer discarded = 0, stored = 0;
  bit done_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_sequencer uut (
    .clk(clk), .rst(rst), .start_stb(start_stb), .clear_stb(clear_stb),
    .pre_count(pre_count), .post_count(post_count), .group_clk(group_clk),
    .trig_sync(trig_sync), .trig_loc(trig_loc), .sample_stb(sample_stb),
    .holdoff_done(holdoff_done), .slow_out(slow_out), .store_en(store_en),
    .acq_done(acq_done)
  );

  task automatic check(input bit ok, input string what, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural model: phase 0 idle,1 pre,2 armed,3 post,4 discard,5 store,6 done
  task enter_readout();
    if (trig_loc == 0) begin ph = 5; left = REC; end
    else begin ph = 4; left = trig_loc; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin ph = 0; left = 0; end
    else case (ph)
      0: if (start_stb) begin
           post_l = post_count;
           if (pre_count == 0) ph = 2; else begin ph = 1; left = pre_count; end
         end
      1: if (group_clk) begin left--; if (left == 0) ph = 2; end
      2: if (trig_sync) begin
           if (post_l == 0) enter_readout(); else begin ph = 3; left = post_l; end
         end
      3: if (group_clk) begin left--; if (left == 0) enter_readout(); end
      4: if (sample_stb) begin left--; if (left == 0) begin ph = 5; left = REC; end end
      5: if (sample_stb) begin left--; if (left == 0) ph = 6; end
      6: if (clear_stb) ph = 0;
      default: ph = 0;
    endcase
  end

  always @(negedge clk) begin
    check(holdoff_done == (ph >= 2), "R3 holdoff_done vs model", holdoff_done, ph >= 2);
    check(slow_out == (ph >= 4), "R5 slow_out vs model", slow_out, ph >= 4);
    check(store_en == (ph == 5), "R8 store_en vs model", store_en, ph == 5);
    check(acq_done == (ph == 6), "R9 acq_done vs model", acq_done, ph == 6);
    if (!rst && sample_stb && store_en) stored++;
    if (!rst && sample_stb && slow_out && !store_en && !acq_done) discarded++;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      finish_run();
    end
  end

  task automatic cyc(input bit gc, input bit tr, input bit ss, input bit st, input bit cl);
    group_clk = gc; trig_sync = tr; sample_stb = ss; start_stb = st; clear_stb = cl;
    @(posedge clk); #1;
    group_clk = 0; trig_sync = 0; sample_stb = 0; start_stb = 0; clear_stb = 0;
  endtask

  task automatic readout(input integer gap_mod, input integer expect_loc);
    for (int i = 0; i < 6000 && !acq_done; i++)
      cyc(0, 0, (gap_mod == 0) ? 1'b1 : ((i % gap_mod) != 2), 0, i == 20);
    check(discarded == expect_loc, "R7 discarded samples", discarded, expect_loc);
    check(stored == REC, "R8 stored samples", stored, REC);
    check(acq_done == 1 && store_en == 0, "R8 done after record", acq_done, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
    check(acq_done == 1, "R9 done holds without clear", acq_done, 1);
    cyc(0, 0, 0, 0, 1);
    check({holdoff_done, slow_out, store_en, acq_done} == 4'b0, "R9 clear returns idle",
          {holdoff_done, slow_out, store_en, acq_done}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({holdoff_done, slow_out, store_en, acq_done} == 4'b0, "R1 outputs in reset",
          {holdoff_done, slow_out, store_en, acq_done}, 0);
    rst = 0;
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 1);
    check({holdoff_done, slow_out, store_en, acq_done} == 4'b0, "R1 idle without start",
          {holdoff_done, slow_out, store_en, acq_done}, 0);

    // capture A: pre 3, post 2, offset 5, with stray strobes
    pre_count = 3; post_count = 2; trig_loc = 5;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    check(slow_out == 0 && holdoff_done == 0, "R4 early trigger ignored", slow_out, 0);
    pre_count = 9;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    check(holdoff_done == 1, "R2 restart while busy ignored", holdoff_done, 1);
    discarded = 0; stored = 0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    check(slow_out == 0, "R6 groups while armed ignored", slow_out, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    check(slow_out == 0, "R5 slow_out not before post count", slow_out, 0);
    cyc(1, 0, 0, 0, 0);
    check(slow_out == 1 && store_en == 0, "R5 slow_out after post count", slow_out, 1);
    check(discarded == 0 && stored == 0, "R10 early samples ignored", discarded, 0);
    readout(5, 5);

    // capture B: zero counts and zero offset
    pre_count = 0; post_count = 0; trig_loc = 0;
    discarded = 0; stored = 0;
    cyc(0, 0, 0, 1, 0);
    check(holdoff_done == 1, "R3 zero pretrigger immediate", holdoff_done, 1);
    cyc(0, 1, 0, 0, 0);
    check(slow_out == 1 && store_en == 1, "R7 zero offset stores at once", store_en, 1);
    readout(0, 0);

    // capture C: long wait for trigger, maximum offset
    pre_count = 1; post_count = 5; trig_loc = 31;
    discarded = 0; stored = 0;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 1100; i++) cyc(1, 0, i[0], 0, 0);
    check(holdoff_done == 1 && slow_out == 0, "R6 armed wait unbounded", slow_out, 0);
    check(discarded == 0 && stored == 0, "R10 armed samples ignored", stored, 0);
    cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
    check(slow_out == 1, "R5 slow_out after five groups", slow_out, 1);
    readout(7, 31);

    finish_run();
  end
endmodule